// File: doc/BRIEF.md
# Condition-Code Flag Register Unit

This block holds the 8-bit condition-code register of a small CPU datapath and computes its arithmetic flags. When the ALU reports a finished operation, the unit receives the operand size, the operation class, both operands and the result. From these it derives half-carry, negative, zero, overflow and carry. The half-carry position follows the operand size: it sits four bits below the top of the active width, so it is bit 3 for bytes, bit 11 for words and bit 27 for longs. The ALU computes the result itself. This unit only observes the operands and the result and updates the flags.

Software can replace the whole register with an 8-bit immediate, or combine it with an immediate by AND, OR or XOR. The current value is always visible on `ccr_o`, which serves as the store path. When an exception sequence begins, the interrupt-mask bit is forced to 1. The output `irq_en_o` tells the interrupt logic whether maskable interrupts may be taken. Non-maskable requests do not depend on this output.

In each cycle at most one of the two update paths acts on the register. A software operation takes precedence over an ALU flag update. An exception start only sets the mask bit, on top of whichever of the two paths acted.

Top module: `ccr_unit`

## Requirements
- R1: During and after reset, with no other activity, `ccr_o` reads 8'h80 (mask set, every other bit 0) and `irq_en_o` is 0.
- R2: Bit layout of `ccr_o`: bit 7 mask, bit 6 user, bit 5 half-carry, bit 4 user, bit 3 negative, bit 2 zero, bit 1 overflow, bit 0 carry. `sw_op_i` = 1 (load) writes `sw_imm_i` into all eight bits at the next clock edge.
- R3: `sw_op_i` = 2, 3 and 4 replace the register with its AND, OR and XOR with `sw_imm_i`. This applies to all eight bits, including both user bits.
- R4: `exc_start_i` = 1 leaves the mask bit at 1 after the edge. This holds even when a software operation in the same cycle clears it. All other bits follow that software operation.
- R5: `irq_en_o` is 1 exactly when the registered mask bit is 0.
- R6: For `alu_size_i` 0/1/2 (byte/word/long), half-carry is the carry or borrow out of bit 3, 11 or 27 respectively.
- R7: Negative takes the top bit of the result at the active size. Zero is 1 exactly when the low 8, 16 or 32 result bits are all 0. Operand and result bits above the active size have no effect.
- R8: Overflow is set on two's-complement overflow at the active size. Add-type operations take dst+src(+C); subtract, compare and extend-subtract take dst−src(−C); negate takes 0−dst.
- R9: Carry is the carry out of the top bit for add-type operations, or the borrow into it for subtract-type and negate. Codes of `alu_op_i`: 0 add, 1 add-with-extend, 2 subtract, 3 subtract-with-extend, 4 compare, 5 negate. The extend forms use the current carry bit as the carry-in.
- R10: An ALU update changes only bits 5, 3, 2, 1 and 0. A cycle with no software operation, no valid ALU update (or `alu_op_i` 6 or 7) and no exception start leaves the register unchanged.
- R11: When a software operation and a valid ALU update arrive in the same cycle, only the software operation takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| exc_start_i | input | 1 | Exception-handling sequence begins this cycle |
| sw_op_i | input | 3 | Software operation: 0 none, 1 load, 2 AND, 3 OR, 4 XOR |
| sw_imm_i | input | 8 | Immediate for the software operation |
| alu_valid_i | input | 1 | ALU result present, update flags |
| alu_size_i | input | 2 | Operand size: 0 byte, 1 word, 2 long (3 treated as long) |
| alu_op_i | input | 3 | Operation class, encoded as in R9 |
| alu_dst_i | input | 32 | Destination operand (minuend for subtraction, operand for negate) |
| alu_src_i | input | 32 | Source operand |
| alu_res_i | input | 32 | Result produced by the ALU |
| ccr_o | output | 8 | Current register value |
| irq_en_o | output | 1 | Maskable interrupts enabled |

## Verification
The flag assertions assume that the ALU result really is the sum or difference of the operands given, with the carry-in from the current carry bit for the extend forms. The bench keeps to this by computing every result itself from the operands before driving it. Software and ALU inputs are applied together only in the cycles that test precedence. Bits above the active size are filled with junk to show they are ignored. The reserved size code 3 is never driven.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int NUM_SIZES = 3;
    localparam int NIBBLE_W  = 4;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } opsize_e;

    typedef enum logic [2:0] {
        AOP_ADD  = 3'd0,
        AOP_ADDX = 3'd1,
        AOP_SUB  = 3'd2,
        AOP_SUBX = 3'd3,
        AOP_CMP  = 3'd4,
        AOP_NEG  = 3'd5,
        AOP_RSV6 = 3'd6,
        AOP_RSV7 = 3'd7
    } alu_op_e;

    typedef enum logic [2:0] {
        SWOP_NONE = 3'd0,
        SWOP_LOAD = 3'd1,
        SWOP_AND  = 3'd2,
        SWOP_OR   = 3'd3,
        SWOP_XOR  = 3'd4,
        SWOP_RSV5 = 3'd5,
        SWOP_RSV6 = 3'd6,
        SWOP_RSV7 = 3'd7
    } sw_op_e;

    typedef struct packed {
        logic imask;
        logic ubit_hi;
        logic half;
        logic ubit_lo;
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } ccr_t;

    typedef struct packed {
        logic half;
        logic neg;
        logic zero;
        logic ovf;
        logic carry;
    } flags_t;

endpackage

// File: rtl/ccr_size_flags.sv
module ccr_size_flags
    import ccr_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [W-1:0] r_i,
    input  logic         sub_i,
    output flags_t       flags_o
);
    localparam int MSB = W - 1;
    localparam int HB  = W - 1 - NIBBLE_W;

    logic [W-1:0] carry_vec_d;
    logic [W-1:0] borrow_vec_d;
    logic [W-1:0] chain_d;
    logic         sign_a_d;
    logic         sign_b_d;
    logic         sign_r_d;

    always_comb begin
        carry_vec_d  = (a_i & b_i) | (a_i & ~r_i) | (b_i & ~r_i);
        borrow_vec_d = (~a_i & b_i) | (~a_i & r_i) | (b_i & r_i);
        chain_d      = sub_i ? borrow_vec_d : carry_vec_d;
        sign_a_d     = a_i[MSB];
        sign_b_d     = b_i[MSB];
        sign_r_d     = r_i[MSB];

        flags_o.half  = chain_d[HB];
        flags_o.carry = chain_d[MSB];
        flags_o.neg   = sign_r_d;
        flags_o.zero  = ~|r_i;
        if (sub_i) begin
            flags_o.ovf = (sign_a_d ^ sign_b_d) & (sign_r_d ^ sign_a_d);
        end else begin
            flags_o.ovf = ~(sign_a_d ^ sign_b_d) & (sign_r_d ^ sign_a_d);
        end
    end

endmodule

// File: rtl/ccr_arith_flags.sv
module ccr_arith_flags
    import ccr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int DATA_W = BYTE_W << (NUM_SIZES - 1)
) (
    input  opsize_e             size_i,
    input  alu_op_e             op_i,
    input  logic [DATA_W-1:0]   dst_i,
    input  logic [DATA_W-1:0]   src_i,
    input  logic [DATA_W-1:0]   res_i,
    output flags_t              flags_o,
    output logic                op_ok_o
);
    logic [DATA_W-1:0] opa_d;
    logic [DATA_W-1:0] opb_d;
    logic              is_sub_d;
    flags_t            per_size_d [NUM_SIZES];

    always_comb begin
        op_ok_o  = 1'b1;
        is_sub_d = 1'b1;
        opa_d    = dst_i;
        opb_d    = src_i;
        unique case (op_i)
            AOP_ADD, AOP_ADDX: is_sub_d = 1'b0;
            AOP_SUB, AOP_SUBX, AOP_CMP: is_sub_d = 1'b1;
            AOP_NEG: begin
                opa_d = '0;
                opb_d = dst_i;
            end
            default: op_ok_o = 1'b0;
        endcase
    end

    for (genvar gi = 0; gi < NUM_SIZES; gi++) begin : g_size
        localparam int SW = BYTE_W << gi;
        ccr_size_flags #(.W(SW)) u_flags (
            .a_i     (opa_d[SW-1:0]),
            .b_i     (opb_d[SW-1:0]),
            .r_i     (res_i[SW-1:0]),
            .sub_i   (is_sub_d),
            .flags_o (per_size_d[gi])
        );
    end

    always_comb begin
        unique case (size_i)
            SZ_BYTE: flags_o = per_size_d[0];
            SZ_WORD: flags_o = per_size_d[1];
            default: flags_o = per_size_d[NUM_SIZES-1];
        endcase
    end

endmodule

// File: rtl/ccr_sw_logic.sv
module ccr_sw_logic
    import ccr_pkg::*;
(
    input  sw_op_e     op_i,
    input  logic [7:0] imm_i,
    input  ccr_t       cur_i,
    output ccr_t       next_o,
    output logic       active_o
);
    logic [7:0] cur_bits_d;
    logic [7:0] new_bits_d;

    always_comb begin
        cur_bits_d = cur_i;
        new_bits_d = cur_bits_d;
        active_o   = 1'b1;
        unique case (op_i)
            SWOP_LOAD: new_bits_d = imm_i;
            SWOP_AND:  new_bits_d = cur_bits_d & imm_i;
            SWOP_OR:   new_bits_d = cur_bits_d | imm_i;
            SWOP_XOR:  new_bits_d = cur_bits_d ^ imm_i;
            default:   active_o   = 1'b0;
        endcase
        next_o = ccr_t'(new_bits_d);
    end

endmodule

// File: rtl/ccr_unit.sv
module ccr_unit
    import ccr_pkg::*;
#(
    parameter int BYTE_W = 8,
    localparam int DATA_W = BYTE_W << (NUM_SIZES - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              exc_start_i,
    input  logic [2:0]        sw_op_i,
    input  logic [7:0]        sw_imm_i,
    input  logic              alu_valid_i,
    input  logic [1:0]        alu_size_i,
    input  logic [2:0]        alu_op_i,
    input  logic [DATA_W-1:0] alu_dst_i,
    input  logic [DATA_W-1:0] alu_src_i,
    input  logic [DATA_W-1:0] alu_res_i,
    output logic [7:0]        ccr_o,
    output logic              irq_en_o
);
    typedef struct packed {
        ccr_t ccr;
    } state_t;

    localparam ccr_t CCR_RESET = '{imask: 1'b1, default: 1'b0};

    state_t state_d;
    state_t state_q;
    ccr_t   sw_next_d;
    logic   sw_active_d;
    flags_t alu_flags_d;
    logic   alu_op_ok_d;

    ccr_sw_logic u_sw (
        .op_i     (sw_op_e'(sw_op_i)),
        .imm_i    (sw_imm_i),
        .cur_i    (state_q.ccr),
        .next_o   (sw_next_d),
        .active_o (sw_active_d)
    );

    ccr_arith_flags #(.BYTE_W(BYTE_W)) u_arith (
        .size_i  (opsize_e'(alu_size_i)),
        .op_i    (alu_op_e'(alu_op_i)),
        .dst_i   (alu_dst_i),
        .src_i   (alu_src_i),
        .res_i   (alu_res_i),
        .flags_o (alu_flags_d),
        .op_ok_o (alu_op_ok_d)
    );

    always_comb begin
        state_d = state_q;
        if (sw_active_d) begin
            state_d.ccr = sw_next_d;
        end else if (alu_valid_i && alu_op_ok_d) begin
            state_d.ccr.half  = alu_flags_d.half;
            state_d.ccr.neg   = alu_flags_d.neg;
            state_d.ccr.zero  = alu_flags_d.zero;
            state_d.ccr.ovf   = alu_flags_d.ovf;
            state_d.ccr.carry = alu_flags_d.carry;
        end
        if (exc_start_i) begin
            state_d.ccr.imask = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.ccr <= CCR_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign ccr_o    = state_q.ccr;
    assign irq_en_o = ~state_q.ccr.imask;

    AST_EXC_SETS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        exc_start_i |=> ccr_o[7]); // R4

    AST_LOAD_WHOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_op_i == 3'd1 && !exc_start_i) |=> ccr_o == $past(sw_imm_i)); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_op_i == 3'd0 && !alu_valid_i && !exc_start_i) |=> $stable(ccr_o)); // R10

    AST_ALU_KEEPS_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_op_i == 3'd0 && alu_valid_i && !exc_start_i)
        |=> (ccr_o[7:6] == $past(ccr_o[7:6])) && (ccr_o[4] == $past(ccr_o[4]))); // R10

    AST_BYTE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_op_i == 3'd0 && alu_valid_i && alu_size_i == 2'd0 && alu_op_i < 3'd6)
        |=> ccr_o[2] == ($past(alu_res_i[7:0]) == 8'd0)); // R7

    AST_BYTE_NEG: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_op_i == 3'd0 && alu_valid_i && alu_size_i == 2'd0 && alu_op_i < 3'd6)
        |=> ccr_o[3] == $past(alu_res_i[7])); // R7

    AST_SW_OVER_ALU: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_op_i == 3'd1 && alu_valid_i && !exc_start_i) |=> ccr_o == $past(sw_imm_i)); // R11

endmodule

// File: tb/ccr_unit_tb.sv
module ccr_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exc_start_i = 1'b0;
    logic [2:0]  sw_op_i = 3'd0;
    logic [7:0]  sw_imm_i = 8'd0;
    logic        alu_valid_i = 1'b0;
    logic [1:0]  alu_size_i = 2'd0;
    logic [2:0]  alu_op_i = 3'd0;
    logic [31:0] alu_dst_i = '0;
    logic [31:0] alu_src_i = '0;
    logic [31:0] alu_res_i = '0;
    logic [7:0]  ccr_o;
    logic        irq_en_o;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model = 8'h80;
    logic [7:0] exp_q [$];
    string      req_q [$];
    bit         done = 1'b0;

    always #4 clk = ~clk;

    ccr_unit u_dut (
        .clk(clk), .rst_n(rst_n), .exc_start_i(exc_start_i),
        .sw_op_i(sw_op_i), .sw_imm_i(sw_imm_i), .alu_valid_i(alu_valid_i),
        .alu_size_i(alu_size_i), .alu_op_i(alu_op_i), .alu_dst_i(alu_dst_i),
        .alu_src_i(alu_src_i), .alu_res_i(alu_res_i), .ccr_o(ccr_o), .irq_en_o(irq_en_o)
    );

    task automatic check(input string req, input logic [7:0] act, input logic act_en,
                         input logic [7:0] exp);
        checks++;
        if (act !== exp || act_en !== ~exp[7]) begin
            fails++;
            $display("FAIL %s: ccr=%h irq_en=%b expected ccr=%h irq_en=%b",
                     req, act, act_en, exp, ~exp[7]);
        end
    endtask

    // Monitor: pops expected values after each registered update
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            logic [7:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            check(r, ccr_o, irq_en_o, e);
        end
    end

    function automatic void alu_model(input int size, input int op, input longint dst,
                                      input longint src, input bit cin,
                                      output longint res, output logic [4:0] hnzvc);
        int w;
        longint mask, hmask, a, b, c, full, sa, sb, sr, lo, hi;
        bit h, n, z, v, cy;
        w     = 8 << size;
        mask  = (64'sd1 <<< w) - 1;
        hmask = (64'sd1 <<< (w - 4)) - 1;
        a = (op == 5) ? 0 : (dst & mask);
        b = (op == 5) ? (dst & mask) : (src & mask);
        c = (op == 1 || op == 3) ? longint'(cin) : 0;
        sa = (a >= (64'sd1 <<< (w - 1))) ? a - (64'sd1 <<< w) : a;
        sb = (b >= (64'sd1 <<< (w - 1))) ? b - (64'sd1 <<< w) : b;
        lo = -(64'sd1 <<< (w - 1));
        hi = (64'sd1 <<< (w - 1)) - 1;
        if (op <= 1) begin
            full = a + b + c;
            cy = ((full >>> w) & 1) != 0;
            h  = ((((a & hmask) + (b & hmask) + c) >>> (w - 4)) & 1) != 0;
            sr = sa + sb + c;
        end else begin
            full = a - b - c;
            cy = a < (b + c);
            h  = (a & hmask) < ((b & hmask) + c);
            sr = sa - sb - c;
        end
        res = full & mask;
        v = (sr < lo) || (sr > hi);
        n = ((res >>> (w - 1)) & 1) != 0;
        z = (res == 0);
        hnzvc = {h, n, z, v, cy};
    endfunction

    // Driver: applies one cycle of stimulus and queues the expected register value
    task automatic drive(input int swop, input logic [7:0] imm, input bit exc,
                         input bit av, input int size, input int aop,
                         input longint dst, input longint src, input string req);
        longint res, mask;
        logic [4:0] f;
        logic [7:0] nx;
        @(negedge clk);
        mask = (64'sd1 <<< (8 << size)) - 1;
        alu_model(size, aop, dst, src, model[0], res, f);
        sw_op_i     = swop[2:0];
        sw_imm_i    = imm;
        exc_start_i = exc;
        alu_valid_i = av;
        alu_size_i  = size[1:0];
        alu_op_i    = aop[2:0];
        alu_dst_i   = 32'(dst & mask) | (32'hA5C3_96E1 & ~32'(mask));
        alu_src_i   = 32'(src & mask) | (32'h5A3C_691E & ~32'(mask));
        alu_res_i   = 32'(res) | (32'hC33C_A55A & ~32'(mask));
        nx = model;
        case (swop)
            1: nx = imm;
            2: nx = model & imm;
            3: nx = model | imm;
            4: nx = model ^ imm;
            default: if (av && aop < 6) begin
                nx[5] = f[4]; nx[3] = f[3]; nx[2] = f[2]; nx[1] = f[1]; nx[0] = f[0];
            end
        endcase
        if (exc) nx[7] = 1'b1;
        model = nx;
        @(posedge clk);
        #1;
        exp_q.push_back(nx);
        req_q.push_back(req);
    endtask

    task automatic sw(input int op, input logic [7:0] imm, input bit exc, input string req);
        drive(op, imm, exc, 1'b0, 0, 0, 0, 0, req);
    endtask

    task automatic alu(input int size, input int op, input longint dst, input longint src,
                       input string req);
        drive(0, 8'h00, 1'b0, 1'b1, size, op, dst, src, req);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 in reset", ccr_o, irq_en_o, 8'h80);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 after reset", ccr_o, irq_en_o, 8'h80);

        sw(1, 8'h00, 0, "R5 load clears mask");
        sw(1, 8'h5A, 0, "R2 load pattern");
        sw(1, 8'hA5, 0, "R2 load complement");
        sw(2, 8'h0F, 0, "R3 and");
        sw(3, 8'h50, 0, "R3 or user bits");
        sw(4, 8'hFF, 0, "R3 xor");
        sw(0, 8'hFF, 0, "R10 idle hold");
        sw(1, 8'h3C, 1, "R4 exception beats load");
        sw(4, 8'h80, 1, "R4 exception beats xor");
        sw(1, 8'h50, 0, "R5 user bits set mask clear");
        sw(0, 8'h00, 1, "R4 exception alone");
        sw(1, 8'h50, 0, "R2 reload");

        alu(0, 0, 64'h0F, 64'h01, "R6 byte half carry");
        alu(0, 0, 64'h7F, 64'h01, "R8 byte signed overflow");
        alu(0, 0, 64'hFF, 64'h01, "R9 R7 byte carry and zero");
        alu(0, 1, 64'h10, 64'hEF, "R9 addx with carry in");
        alu(0, 2, 64'h10, 64'h01, "R6 byte half borrow");
        alu(0, 2, 64'h00, 64'h01, "R9 byte borrow");
        alu(0, 3, 64'h05, 64'h04, "R9 subx with carry in");
        alu(0, 4, 64'h80, 64'h01, "R8 compare overflow");
        alu(0, 5, 64'h00, 64'h00, "R7 negate zero");
        alu(0, 5, 64'h80, 64'h00, "R8 negate min");
        alu(0, 5, 64'h01, 64'h00, "R9 negate borrow");
        alu(1, 0, 64'h0FFF, 64'h0001, "R6 word half at bit 11");
        alu(1, 0, 64'h00FF, 64'h0001, "R6 word no half at bit 3");
        alu(1, 2, 64'h8000, 64'h0001, "R8 word sub overflow");
        alu(1, 0, 64'hFFFF, 64'h0001, "R7 word zero");
        alu(2, 0, 64'h0FFFFFFF, 64'h1, "R6 long half at bit 27");
        alu(2, 0, 64'h7FFFFFFF, 64'h1, "R8 long overflow");
        alu(2, 2, 64'h0, 64'h1, "R9 long borrow");
        alu(2, 4, 64'h12345678, 64'h12345678, "R7 long compare equal");
        drive(0, 8'h00, 0, 1'b1, 0, 6, 64'hFF, 64'h01, "R10 reserved op ignored");
        drive(1, 8'h0F, 0, 1'b1, 0, 0, 64'h7F, 64'h01, "R11 load beats alu");
        drive(3, 8'h40, 0, 1'b1, 0, 2, 64'h00, 64'h01, "R11 or beats alu");
        alu(0, 0, 64'h01, 64'h01, "R10 alu keeps mask and user bits");
        sw(0, 8'h00, 0, "R10 idle after alu");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 5000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not finish, actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule